// File: doc/BRIEF.md
# Transmit Mode Exit Controller

This block holds the 8-bit operating-mode register of a radio transceiver and runs the operating state that goes with it. The host writes the register to pick one of four states: STANDBY, READY (crystal oscillator running), TUNE (oscillator and synthesizer running) or TX. While in TX the block watches the transmit FIFO. When the FIFO runs dry and no refill arrives in that cycle, the block raises a one-cycle packet-sent pulse, clears its own transmit-enable bit and drops into an exit state.

The exit state is TUNE if the PLL-on bit is set and READY otherwise. A bare transmit request therefore ends in READY and not in STANDBY. The oscillator keeps running, because a host clocked from that oscillator must still have time to service the packet-sent event. Only an explicit host write of a value with no mode bits set reaches STANDBY. The other register bits are stored and read back but have no effect. The block drives the oscillator enable and the synthesizer enable directly from its state.

Top module: `tx_mode_ctrl`

## Requirements
- R1: The state encoding is STANDBY=0, READY=1, TUNE=2, TX=3. A register write with bit 3 (transmit-enable) set moves `op_state` to TX at the clock edge that takes the write, whatever the current state. This includes writes made while already in TX.
- R2: In TX, a clock edge that sees `fifo_empty` high and `fifo_push` low is a completion. `pkt_sent` is high for exactly the cycle after that edge, and `op_state` has left TX in that same cycle.
- R3: A completion clears bit 3 of `mode_rdata` and leaves every other register bit unchanged.
- R4: A completion with bit 1 (PLL-on) set goes to TUNE. Writing 0x0A therefore ends in TUNE.
- R5: A completion with bit 1 clear goes to READY, whether or not bit 0 (crystal-on) is set. Writing 0x09 or 0x08 ends in READY.
- R6: After a completion from a bare 0x08, the state stays READY while the register reads 0x00, until the host writes again.
- R7: A write with bit 3 clear picks the state at once: TUNE if bit 1 is set, else READY if bit 0 is set, else STANDBY. A write is the only way into STANDBY.
- R8: `osc_en` is high in READY, TUNE and TX and low in STANDBY. `pll_en` is high in TUNE and TX and low in STANDBY and READY.
- R9: In TX, an edge with `fifo_push` high is never a completion, even when `fifo_empty` is high. The state stays TX and no pulse is issued.
- R10: Bits 7:4 and bit 2 are stored and read back on `mode_rdata` and have no effect on state or enables.
- R11: Synchronous reset clears the register to 0x00 and the state to STANDBY, and holds `pkt_sent` low.
- R12: When a host write falls on the same edge as a completion, the written value sets the register and the state, and `pkt_sent` still pulses in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Host write strobe for the mode register |
| mode_wdata | input | 8 | Value written to the mode register |
| fifo_empty | input | 1 | Transmit FIFO holds no data |
| fifo_push | input | 1 | Host is loading a byte into the transmit FIFO this cycle |
| mode_rdata | output | 8 | Current mode register contents |
| op_state | output | 2 | Operating state (0 STANDBY, 1 READY, 2 TUNE, 3 TX) |
| pkt_sent | output | 1 | One-cycle packet-sent pulse |
| osc_en | output | 1 | Crystal oscillator enable |
| pll_en | output | 1 | Synthesizer enable |

## Verification
Two events can fall on the same clock edge: a host write to the mode register and the automatic completion of a transmission. Each tries to rewrite the register and the state. The bench provokes this by raising `fifo_empty` in the same cycle as a write. It does this once with a value that leaves transmit and once with a value that re-enters it. It then checks that the written value wins for the register and the state while the packet-sent pulse still appears. A second collision it provokes is a refill on the very edge where the FIFO reads empty. There it checks that transmission continues with no pulse.

// File: rtl/txm_pkg.sv
package txm_pkg;

    localparam int MODE_W   = 8;
    localparam int TX_BIT   = 3;
    localparam int PLL_BIT  = 1;
    localparam int XTAL_BIT = 0;

    typedef enum logic [1:0] {
        ST_STANDBY = 2'd0,
        ST_READY   = 2'd1,
        ST_TUNE    = 2'd2,
        ST_TX      = 2'd3
    } op_state_e;

    typedef struct packed {
        logic osc;
        logic pll;
    } clk_en_t;

    // State selected directly by a host write.
    function automatic op_state_e state_from_write(input logic [MODE_W-1:0] v);
        if (v[TX_BIT])        return ST_TX;
        else if (v[PLL_BIT])  return ST_TUNE;
        else if (v[XTAL_BIT]) return ST_READY;
        else                  return ST_STANDBY;
    endfunction

    // Landing state once a transmission has finished.
    function automatic op_state_e state_after_tx(input logic [MODE_W-1:0] v);
        return v[PLL_BIT] ? ST_TUNE : ST_READY;
    endfunction

    function automatic clk_en_t enables_for(input op_state_e s);
        clk_en_t e;
        e.osc = (s != ST_STANDBY);
        e.pll = (s == ST_TUNE) || (s == ST_TX);
        return e;
    endfunction

endpackage

// File: rtl/txm_mode_reg.sv
module txm_mode_reg
    import txm_pkg::*;
#(
    parameter int W      = MODE_W,
    parameter int TX_POS = TX_BIT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         tx_done,
    output logic [W-1:0] mode_q
);

    logic [W-1:0] clr_mask;

    always_comb begin
        clr_mask         = '1;
        clr_mask[TX_POS] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)          mode_q <= '0;
        else if (wr_en)   mode_q <= wr_data;
        else if (tx_done) mode_q <= mode_q & clr_mask;
    end

    assert_tx_bit_cleared_R3: assert property (@(posedge clk) disable iff (rst)
        ($past(tx_done) && !$past(wr_en)) |-> (!mode_q[TX_POS] &&
            ((mode_q & clr_mask) == ($past(mode_q) & clr_mask))));

    assert_write_wins_R12: assert property (@(posedge clk) disable iff (rst)
        $past(wr_en) |-> (mode_q == $past(wr_data)));

endmodule

// File: rtl/txm_sequencer.sv
module txm_sequencer
    import txm_pkg::*;
#(
    parameter int W = MODE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] mode_q,
    input  logic         fifo_empty,
    input  logic         fifo_push,
    output logic         tx_done,
    output op_state_e    cur_state,
    output logic         pkt_pulse
);

    // Completion: drained FIFO and no refill on this edge.
    assign tx_done = (cur_state == ST_TX) && fifo_empty && !fifo_push;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_state <= ST_STANDBY;
            pkt_pulse <= 1'b0;
        end else begin
            pkt_pulse <= tx_done;
            if (wr_en)        cur_state <= state_from_write(wr_data);
            else if (tx_done) cur_state <= state_after_tx(mode_q);
        end
    end

    assert_tx_needs_enable_R1: assert property (@(posedge clk) disable iff (rst)
        (cur_state == ST_TX) |-> mode_q[TX_BIT]);

    assert_pulse_after_tx_R2: assert property (@(posedge clk) disable iff (rst)
        pkt_pulse |-> ($past(cur_state) == ST_TX));

    assert_standby_by_write_R7: assert property (@(posedge clk) disable iff (rst)
        ((cur_state == ST_STANDBY) && ($past(cur_state) != ST_STANDBY)) |-> $past(wr_en));

    assert_refill_holds_R9: assert property (@(posedge clk) disable iff (rst)
        ($past(cur_state) == ST_TX && $past(fifo_push) && !$past(wr_en))
            |-> (cur_state == ST_TX && !pkt_pulse));

    assert_exit_target_R4: assert property (@(posedge clk) disable iff (rst)
        ($past(tx_done) && !$past(wr_en))
            |-> (cur_state == ($past(mode_q[PLL_BIT]) ? ST_TUNE : ST_READY)));

endmodule

// File: rtl/txm_enable_dec.sv
module txm_enable_dec
    import txm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  op_state_e cur_state,
    output logic      osc_en,
    output logic      pll_en
);

    clk_en_t en;

    always_comb en = enables_for(cur_state);

    assign osc_en = en.osc;
    assign pll_en = en.pll;

    assert_pll_implies_osc_R8: assert property (@(posedge clk) disable iff (rst)
        pll_en |-> osc_en);

endmodule

// File: rtl/tx_mode_ctrl.sv
module tx_mode_ctrl
    import txm_pkg::*;
#(
    parameter int W = MODE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         mode_wr,
    input  logic [W-1:0] mode_wdata,
    input  logic         fifo_empty,
    input  logic         fifo_push,
    output logic [W-1:0] mode_rdata,
    output logic [1:0]   op_state,
    output logic         pkt_sent,
    output logic         osc_en,
    output logic         pll_en
);

    logic         tx_done;
    logic [W-1:0] mode_q;
    op_state_e    cur_state;

    txm_mode_reg #(.W(W), .TX_POS(TX_BIT)) u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (mode_wr),
        .wr_data (mode_wdata),
        .tx_done (tx_done),
        .mode_q  (mode_q)
    );

    txm_sequencer #(.W(W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (mode_wr),
        .wr_data    (mode_wdata),
        .mode_q     (mode_q),
        .fifo_empty (fifo_empty),
        .fifo_push  (fifo_push),
        .tx_done    (tx_done),
        .cur_state  (cur_state),
        .pkt_pulse  (pkt_sent)
    );

    txm_enable_dec u_en (
        .clk       (clk),
        .rst       (rst),
        .cur_state (cur_state),
        .osc_en    (osc_en),
        .pll_en    (pll_en)
    );

    assign mode_rdata = mode_q;
    assign op_state   = cur_state;

    assert_reset_state_R11: assert property (@(posedge clk)
        $past(rst) |-> (op_state == 2'd0 && mode_rdata == '0 && !pkt_sent));

endmodule

// File: tb/tx_mode_ctrl_test.sv
`timescale 1ns/1ps
module tx_mode_ctrl_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_wr = 1'b0;
    logic [7:0] mode_wdata = 8'h00;
    logic       fifo_empty = 1'b0;
    logic       fifo_push = 1'b0;
    logic [7:0] mode_rdata;
    logic [1:0] op_state;
    logic       pkt_sent, osc_en, pll_en;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    tx_mode_ctrl uut (
        .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .fifo_empty(fifo_empty), .fifo_push(fifo_push), .mode_rdata(mode_rdata),
        .op_state(op_state), .pkt_sent(pkt_sent), .osc_en(osc_en), .pll_en(pll_en)
    );

    // Behavioural reference model
    int m_reg = 0;
    int m_st  = 0;
    int m_pkt = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_reg <= 0; m_st <= 0; m_pkt <= 0;
        end else begin
            bit fin;
            fin = (m_st == 3) && fifo_empty && !fifo_push;
            m_pkt <= fin ? 1 : 0;
            if (mode_wr) begin
                m_reg <= mode_wdata;
                if (mode_wdata[3])      m_st <= 3;
                else if (mode_wdata[1]) m_st <= 2;
                else if (mode_wdata[0]) m_st <= 1;
                else                    m_st <= 0;
            end else if (fin) begin
                m_reg <= m_reg & 8'hF7;
                m_st  <= ((m_reg & 2) != 0) ? 2 : 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Every-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk(op_state == m_st[1:0], "R1 state", op_state, m_st);
            chk(pkt_sent == m_pkt[0], "R2 pkt_sent", pkt_sent, m_pkt);
            chk(mode_rdata == m_reg[7:0], "R3 mode_rdata", mode_rdata, m_reg);
            chk(osc_en == (m_st != 0), "R8 osc_en", osc_en, (m_st != 0));
            chk(pll_en == (m_st >= 2), "R8 pll_en", pll_en, (m_st >= 2));
        end
    end

    task automatic wr(input logic [7:0] d);
        mode_wr = 1'b1; mode_wdata = d;
        @(negedge clk);
        mode_wr = 1'b0;
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(op_state == 0 && mode_rdata == 0 && !pkt_sent, "R11 reset", op_state, 0);

        // R7 direct selection
        wr(8'h01); chk(op_state == 1, "R7 xtal write", op_state, 1);
        wr(8'h03); chk(op_state == 2, "R7 pll write", op_state, 2);
        wr(8'h00); chk(op_state == 0, "R7 zero write", op_state, 0);

        // R4: 0x0A ends in TUNE
        wr(8'h0A); chk(op_state == 3, "R1 enter tx", op_state, 3);
        wr(8'h08); chk(op_state == 3, "R1 write in tx", op_state, 3);
        wr(8'h0A);
        repeat (3) @(negedge clk);
        fifo_empty = 1'b1;
        @(negedge clk);
        chk(pkt_sent == 1'b1, "R2 pulse", pkt_sent, 1);
        chk(op_state == 2, "R4 exit tune", op_state, 2);
        chk(mode_rdata == 8'h02, "R3 clear bit", mode_rdata, 8'h02);
        @(negedge clk);
        chk(pkt_sent == 1'b0, "R2 single pulse", pkt_sent, 0);

        // R5: 0x09 ends in READY
        fifo_empty = 1'b0;
        wr(8'h09);
        @(negedge clk);
        fifo_empty = 1'b1;
        @(negedge clk);
        chk(op_state == 1 && mode_rdata == 8'h01, "R5 exit ready", op_state, 1);

        // R6: bare request stays READY
        fifo_empty = 1'b0;
        wr(8'h08);
        fifo_empty = 1'b1;
        @(negedge clk);
        chk(op_state == 1 && mode_rdata == 8'h00, "R5 bare exit", op_state, 1);
        repeat (5) @(negedge clk);
        chk(op_state == 1 && osc_en, "R6 held ready", op_state, 1);
        wr(8'h00); chk(op_state == 0 && !osc_en, "R7 standby write", op_state, 0);

        // R9: refill on an empty edge
        fifo_push = 1'b1;
        wr(8'h08);
        repeat (3) @(negedge clk);
        chk(op_state == 3 && !pkt_sent, "R9 refill keeps tx", op_state, 3);
        fifo_push = 1'b0;
        @(negedge clk);
        chk(pkt_sent == 1'b1 && op_state == 1, "R9 drain after refill", op_state, 1);

        // R10: other bits have no effect
        fifo_empty = 1'b0;
        wr(8'hF4); chk(op_state == 0 && mode_rdata == 8'hF4, "R10 f4", mode_rdata, 8'hF4);
        wr(8'hF5); chk(op_state == 1, "R10 f5", op_state, 1);
        wr(8'h76); chk(op_state == 2 && mode_rdata == 8'h76, "R10 76", op_state, 2);
        wr(8'hFC);
        fifo_empty = 1'b1;
        @(negedge clk);
        chk(op_state == 1 && mode_rdata == 8'hF4, "R10 exit keeps bits", mode_rdata, 8'hF4);

        // R12: write and completion on one edge
        fifo_empty = 1'b0;
        wr(8'h08);
        fifo_empty = 1'b1;
        wr(8'h03);
        chk(pkt_sent && op_state == 2 && mode_rdata == 8'h03, "R12 write leaves", mode_rdata, 8'h03);
        fifo_empty = 1'b0;
        wr(8'h08);
        fifo_empty = 1'b1;
        wr(8'h0A);
        chk(pkt_sent && op_state == 3 && mode_rdata == 8'h0A, "R12 write reenters", mode_rdata, 8'h0A);
        @(negedge clk);
        chk(pkt_sent && op_state == 2, "R12 then completes", op_state, 2);
        fifo_empty = 1'b0;
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule